// File: doc/BRIEF.md
# Dual-Converter Sample Slot Scan Sequencer

This block decides which sample slot is converted next and which converter engine runs it. There are sixteen slots. Each slot carries a channel number and an enable bit. The lower half of the slots belongs to converter A and the upper half to converter B. A scan walks the slots in ascending order and issues one convert request at a time per converter, carrying the slot's channel number. It then waits for that converter's done strobe, stores the returned result in the slot's result register and raises the slot's ready flag. The length of a scan is not a count. A scan ends at the first disabled slot it meets, or after the last slot of its range. At that point an end-of-scan flag is raised.

Three scan modes decide how the two converters share the work. Sequential mode walks all sixteen slots under converter A's controls and steers each request to the converter that owns the slot. Simultaneous parallel mode runs both halves at once under converter A's controls and ends both as soon as either half ends. Independent parallel mode gives each half its own start, stop and sync. Three repeat types decide what starts a scan: once, looping and triggered. The software writes one to a ready or end-of-scan flag to clear it.

Top module: `scan_sequencer`

## Requirements
- R1: After reset, every ready flag, both end-of-scan flags and both convert request outputs are low.
- R2: In sequential mode (mode code 0), a scan walks slots upward from slot 0 and ends at the first disabled slot. Slots below 8 are requested on converter A and slots 8 and above on converter B. End of scan sets `eos_o[0]` only.
- R3: In sequential mode with all sixteen slots enabled, the scan converts all sixteen slots and ends after slot 15.
- R4: In simultaneous parallel mode (mode code 1), start, stop and sync come from the A-side inputs, and the B-side start has no effect. A walks slots 0 to 7 while B walks slots 8 to 15. Both end as soon as either one reaches a disabled slot or its last slot. Each half therefore converts the shorter of the two enabled prefixes. Only `eos_o[0]` is set.
- R5: In independent parallel mode (mode code 2), each converter starts, stops and ends on its own inputs and its own first disabled or last slot. A sets `eos_o[0]` and B sets `eos_o[1]`.
- R6: With repeat code 0 (once), only the start strobe begins a scan, and a sync pulse has no effect.
- R7: With repeat code 1 (looping), a finished scan restarts at once from its first slot. Start and sync pulses during the run are ignored. Only stop ends the loop, and releasing stop does not restart it.
- R8: With repeat code 2 (triggered), a sync pulse starts a scan when that side's sync enable is high and the side is idle. A sync pulse during a scan, or one with sync enable low, is dropped.
- R9: A stored slot sets ready bit i for slot i and places the result in `result_o[i*12 +: 12]`. Writing one to a bit of `ready_clr_i` or `eos_clr_i` clears that flag on the next cycle.
- R10: A scan whose first slot is disabled issues no request and sets its end-of-scan flag. In looping mode it does not restart.
- R11: Stop lets the conversion in flight finish but discards its result. It sets no end-of-scan flag and issues no further request while held.
- R12: A converter never receives a new convert request before the done strobe of its previous one.
- R13: The channel sent with each request is the channel number of the slot being converted, 4 bits per slot at `slot_chan_i[i*4 +: 4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Scan mode: 0 sequential, 1 simultaneous, 2 independent |
| rpt_a_i | input | 2 | A-side repeat type: 0 once, 1 looping, 2 triggered |
| rpt_b_i | input | 2 | B-side repeat type (independent mode only) |
| slot_en_i | input | 16 | Enable bit per slot |
| slot_chan_i | input | 64 | Channel number per slot, 4 bits each |
| start_a_i | input | 1 | A-side software start strobe |
| stop_a_i | input | 1 | A-side stop level |
| sync_a_i | input | 1 | A-side sync pulse |
| sync_en_a_i | input | 1 | A-side sync enable |
| start_b_i | input | 1 | B-side software start strobe |
| stop_b_i | input | 1 | B-side stop level |
| sync_b_i | input | 1 | B-side sync pulse |
| sync_en_b_i | input | 1 | B-side sync enable |
| conv_a_req_o | output | 1 | Convert request to converter A |
| conv_a_chan_o | output | 4 | Channel for converter A's request |
| conv_a_done_i | input | 1 | Converter A done strobe |
| conv_a_data_i | input | 12 | Converter A result |
| conv_b_req_o | output | 1 | Convert request to converter B |
| conv_b_chan_o | output | 4 | Channel for converter B's request |
| conv_b_done_i | input | 1 | Converter B done strobe |
| conv_b_data_i | input | 12 | Converter B result |
| ready_o | output | 16 | Ready flag per slot |
| ready_clr_i | input | 16 | Write-one-to-clear for ready flags |
| eos_o | output | 2 | End-of-scan flags, bit 0 A, bit 1 B |
| eos_clr_i | input | 2 | Write-one-to-clear for end-of-scan flags |
| result_o | output | 192 | Stored result per slot, 12 bits each |

## Verification
The bench builds the block with its defaults: sixteen slots, 4-bit channels and 12-bit results. A fixed-latency converter model in the bench answers every request with a value computed from the converter, the channel and a per-test tag. With sixteen slots, every position of the first disabled slot in sequential mode is in reach, from the empty scan to the full scan. All 81 pairs of enabled-prefix lengths on the two halves are in reach in simultaneous mode. Because the converter latency is small, looping runs with several restarts, and stops that land mid-conversion, fit in a few hundred cycles.

// File: rtl/scan_seq_pkg.sv
// Shared encodings for the scan sequencer: scan modes, repeat types and
// the per-converter walker state.
package scan_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SEQ = 2'd0,
        MODE_SIM = 2'd1,
        MODE_IND = 2'd2
    } scan_mode_e;

    typedef enum logic [1:0] {
        RPT_ONCE = 2'd0,
        RPT_LOOP = 2'd1,
        RPT_TRIG = 2'd2
    } scan_rpt_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_EVAL,
        W_WAIT,
        W_FLUSH
    } walk_state_e;

endpackage

// File: rtl/scan_walker.sv
// Slot walker: steps one slot index from lo_i towards hi_i. For each
// enabled slot it issues a one-cycle request, then waits for done_i.
// It ends at a disabled slot, after hi_i, or when kill_i / a remembered
// kill says the partner walker has ended. halt_i aborts: the conversion in
// flight is awaited and dropped, and no eos pulse is produced.
// Assumes lo_i, hi_i and loop_i stay constant while the walker is busy.
module scan_walker #(
    parameter int NSLOT = 16,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             halt_i,
    input  logic             loop_i,
    input  logic [SW-1:0]    lo_i,
    input  logic [SW-1:0]    hi_i,
    input  logic [NSLOT-1:0] en_i,
    input  logic             kill_i,
    input  logic             done_i,
    output logic             req_o,
    output logic [SW-1:0]    slot_o,
    output logic             store_o,
    output logic             end_o,
    output logic             eos_o
);
    import scan_seq_pkg::*;

    walk_state_e   state;
    logic [SW-1:0] idx;
    logic          killed;
    logic          slot_on;
    logic          kill_any;
    logic          fin_eval;
    logic          fin_wait;
    logic          finish;
    logic          empty;

    // Decode the end conditions and the outputs from the current state.
    always_comb begin
        slot_on  = en_i[idx];
        kill_any = kill_i | killed;
        end_o    = ((state == W_EVAL) && !halt_i && !slot_on) ||
                   ((state == W_WAIT) && done_i && !halt_i && (idx == hi_i));
        fin_eval = (state == W_EVAL) && !halt_i && (!slot_on || kill_any);
        fin_wait = (state == W_WAIT) && done_i && !halt_i &&
                   ((idx == hi_i) || kill_any);
        finish   = fin_eval | fin_wait;
        empty    = fin_eval && (idx == lo_i);
        req_o    = (state == W_EVAL) && !halt_i && slot_on && !kill_any;
        store_o  = (state == W_WAIT) && done_i && !halt_i;
        eos_o    = finish;
        slot_o   = idx;
    end

    // Walker state, slot index and remembered partner kill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= W_IDLE;
            idx    <= '0;
            killed <= 1'b0;
        end else begin
            if (state == W_WAIT && kill_i) begin
                killed <= 1'b1;
            end
            case (state)
                W_IDLE: begin
                    if (go_i && !halt_i) begin
                        state  <= W_EVAL;
                        idx    <= lo_i;
                        killed <= 1'b0;
                    end
                end
                W_EVAL: begin
                    if (halt_i) begin
                        state <= W_IDLE;
                    end else if (finish) begin
                        if (loop_i && !empty) begin
                            idx    <= lo_i;
                            killed <= 1'b0;
                        end else begin
                            state <= W_IDLE;
                        end
                    end else begin
                        state <= W_WAIT;
                    end
                end
                W_WAIT: begin
                    if (halt_i) begin
                        state <= done_i ? W_IDLE : W_FLUSH;
                    end else if (done_i) begin
                        if (finish) begin
                            if (loop_i) begin
                                state  <= W_EVAL;
                                idx    <= lo_i;
                                killed <= 1'b0;
                            end else begin
                                state <= W_IDLE;
                            end
                        end else begin
                            state <= W_EVAL;
                            idx   <= idx + 1'b1;
                        end
                    end
                end
                default: begin
                    if (done_i) begin
                        state <= W_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/scan_flags.sv
// Result and flag store: captures results for the slots named by the two
// walkers' store strobes and keeps per-slot ready flags and two
// end-of-scan flags. All flags are cleared by writing one. A set and a
// clear in the same cycle leave the flag set.
module scan_flags #(
    parameter int NSLOT = 16,
    parameter int RW    = 12,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st0_i,
    input  logic [SW-1:0]       slot0_i,
    input  logic [RW-1:0]       data0_i,
    input  logic                st1_i,
    input  logic [SW-1:0]       slot1_i,
    input  logic [RW-1:0]       data1_i,
    input  logic [1:0]          eos_set_i,
    input  logic [NSLOT-1:0]    ready_clr_i,
    input  logic [1:0]          eos_clr_i,
    output logic [NSLOT-1:0]    ready_o,
    output logic [1:0]          eos_o,
    output logic [NSLOT*RW-1:0] result_o
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic hit0;
        logic hit1;
        assign hit0 = st0_i && (slot0_i == SW'(s));
        assign hit1 = st1_i && (slot1_i == SW'(s));

        // Per-slot result capture and ready flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result_o[s*RW +: RW] <= '0;
                ready_o[s]           <= 1'b0;
            end else begin
                if (hit0) begin
                    result_o[s*RW +: RW] <= data0_i;
                end else if (hit1) begin
                    result_o[s*RW +: RW] <= data1_i;
                end
                if (hit0 || hit1) begin
                    ready_o[s] <= 1'b1;
                end else if (ready_clr_i[s]) begin
                    ready_o[s] <= 1'b0;
                end
            end
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_eos
        // End-of-scan flag per converter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                eos_o[c] <= 1'b0;
            end else if (eos_set_i[c]) begin
                eos_o[c] <= 1'b1;
            end else if (eos_clr_i[c]) begin
                eos_o[c] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/scan_sequencer.sv
// Dual-converter slot scan sequencer top. Two slot walkers are set up
// according to the scan mode. In sequential mode walker 0 covers every
// slot and each request is steered to the converter that owns the slot.
// In simultaneous mode both walkers run on A-side controls and kill each
// other when one ends. In independent mode each walker has its own
// controls. Assumes mode and repeat inputs change only while idle.
module scan_sequencer #(
    parameter int NSLOT = 16,
    parameter int CHW   = 4,
    parameter int RW    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_i,
    input  logic [1:0]           rpt_a_i,
    input  logic [1:0]           rpt_b_i,
    input  logic [NSLOT-1:0]     slot_en_i,
    input  logic [NSLOT*CHW-1:0] slot_chan_i,
    input  logic                 start_a_i,
    input  logic                 stop_a_i,
    input  logic                 sync_a_i,
    input  logic                 sync_en_a_i,
    input  logic                 start_b_i,
    input  logic                 stop_b_i,
    input  logic                 sync_b_i,
    input  logic                 sync_en_b_i,
    output logic                 conv_a_req_o,
    output logic [CHW-1:0]       conv_a_chan_o,
    input  logic                 conv_a_done_i,
    input  logic [RW-1:0]        conv_a_data_i,
    output logic                 conv_b_req_o,
    output logic [CHW-1:0]       conv_b_chan_o,
    input  logic                 conv_b_done_i,
    input  logic [RW-1:0]        conv_b_data_i,
    output logic [NSLOT-1:0]     ready_o,
    input  logic [NSLOT-1:0]     ready_clr_i,
    output logic [1:0]           eos_o,
    input  logic [1:0]           eos_clr_i
    ,
    output logic [NSLOT*RW-1:0]  result_o
);
    import scan_seq_pkg::*;

    localparam int SW   = $clog2(NSLOT);
    localparam int HALF = NSLOT / 2;
    localparam logic [SW-1:0] LO_A  = '0;
    localparam logic [SW-1:0] HI_A  = SW'(HALF - 1);
    localparam logic [SW-1:0] LO_B  = SW'(HALF);
    localparam logic [SW-1:0] HI_ALL = SW'(NSLOT - 1);

    logic          is_sim, is_ind, is_seq;
    logic          trig_a, trig_b;
    logic          w0_go, w0_halt, w0_loop, w0_kill, w0_done;
    logic [SW-1:0] w0_hi;
    logic          w1_go, w1_halt, w1_loop, w1_kill;
    logic          w0_req, w0_store, w0_end, w0_eos;
    logic          w1_req, w1_store, w1_end, w1_eos;
    logic [SW-1:0] w0_slot, w1_slot;
    logic          w0_on_b;
    logic [RW-1:0] w0_data;

    // Mode decode, start triggers and walker control routing.
    always_comb begin
        is_sim  = (mode_i == MODE_SIM);
        is_ind  = (mode_i == MODE_IND);
        is_seq  = !is_sim && !is_ind;
        trig_a  = start_a_i | (sync_a_i & sync_en_a_i & (rpt_a_i != RPT_ONCE));
        trig_b  = start_b_i | (sync_b_i & sync_en_b_i & (rpt_b_i != RPT_ONCE));
        w0_go   = trig_a;
        w0_halt = stop_a_i;
        w0_loop = (rpt_a_i == RPT_LOOP);
        w0_hi   = is_seq ? HI_ALL : HI_A;
        w0_kill = is_sim & w1_end;
        w0_on_b = is_seq && (w0_slot >= LO_B);
        w0_done = w0_on_b ? conv_b_done_i : conv_a_done_i;
        w0_data = w0_on_b ? conv_b_data_i : conv_a_data_i;
        w1_go   = is_ind ? trig_b : (is_sim & trig_a);
        w1_halt = is_ind ? stop_b_i : stop_a_i;
        w1_loop = is_ind ? (rpt_b_i == RPT_LOOP) : (rpt_a_i == RPT_LOOP);
        w1_kill = is_sim & w0_end;
    end

    // Converter request steering and channel lookup.
    always_comb begin
        conv_a_req_o  = w0_req & !w0_on_b;
        conv_a_chan_o = slot_chan_i[int'(w0_slot)*CHW +: CHW];
        conv_b_req_o  = (w0_req & w0_on_b) | w1_req;
        conv_b_chan_o = w0_on_b ? slot_chan_i[int'(w0_slot)*CHW +: CHW]
                                : slot_chan_i[int'(w1_slot)*CHW +: CHW];
    end

    scan_walker #(.NSLOT(NSLOT), .SW(SW)) u_walk_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (w0_go),
        .halt_i  (w0_halt),
        .loop_i  (w0_loop),
        .lo_i    (LO_A),
        .hi_i    (w0_hi),
        .en_i    (slot_en_i),
        .kill_i  (w0_kill),
        .done_i  (w0_done),
        .req_o   (w0_req),
        .slot_o  (w0_slot),
        .store_o (w0_store),
        .end_o   (w0_end),
        .eos_o   (w0_eos)
    );

    scan_walker #(.NSLOT(NSLOT), .SW(SW)) u_walk_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (w1_go),
        .halt_i  (w1_halt),
        .loop_i  (w1_loop),
        .lo_i    (LO_B),
        .hi_i    (HI_ALL),
        .en_i    (slot_en_i),
        .kill_i  (w1_kill),
        .done_i  (conv_b_done_i),
        .req_o   (w1_req),
        .slot_o  (w1_slot),
        .store_o (w1_store),
        .end_o   (w1_end),
        .eos_o   (w1_eos)
    );

    scan_flags #(.NSLOT(NSLOT), .RW(RW), .SW(SW)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .st0_i       (w0_store),
        .slot0_i     (w0_slot),
        .data0_i     (w0_data),
        .st1_i       (w1_store),
        .slot1_i     (w1_slot),
        .data1_i     (conv_b_data_i),
        .eos_set_i   ({is_ind & w1_eos, w0_eos}),
        .ready_clr_i (ready_clr_i),
        .eos_clr_i   (eos_clr_i),
        .ready_o     (ready_o),
        .eos_o       (eos_o),
        .result_o    (result_o)
    );

endmodule

// File: rtl/scan_sequencer_chk.sv
// Property checker for scan_sequencer, attached by bind. It watches the
// converter handshakes, the flags and the stop input at the ports.
module scan_sequencer_chk #(
    parameter int NSLOT = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             stop_a_i,
    input logic             conv_a_req_o,
    input logic             conv_a_done_i,
    input logic             conv_b_req_o,
    input logic             conv_b_done_i,
    input logic [NSLOT-1:0] ready_o,
    input logic [NSLOT-1:0] ready_clr_i,
    input logic [1:0]       eos_o
);
    logic out_a;
    logic out_b;

    // Track whether each converter has a request awaiting its done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a <= 1'b0;
            out_b <= 1'b0;
        end else begin
            if (conv_a_req_o) out_a <= 1'b1;
            else if (conv_a_done_i) out_a <= 1'b0;
            if (conv_b_req_o) out_b <= 1'b1;
            else if (conv_b_done_i) out_b <= 1'b0;
        end
    end

    AST_ONE_OUTSTANDING_A: assert property (@(posedge clk) disable iff (!rst_n)
        conv_a_req_o |-> !out_a); // R12
    AST_ONE_OUTSTANDING_B: assert property (@(posedge clk) disable iff (!rst_n)
        conv_b_req_o |-> !out_b); // R12
    AST_READY_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_o & ~$past(ready_o)) != '0) |-> $past(conv_a_done_i || conv_b_done_i)); // R9
    AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ready_clr_i) && !conv_a_done_i && !conv_b_done_i) |=> ((ready_o & $past(ready_clr_i)) == '0)); // R9
    AST_EOS_B_ONLY_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eos_o[1]) |-> ($past(mode_i) == 2'd2)); // R4
    AST_STOP_HOLDS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_a_i && $past(stop_a_i)) |-> !conv_a_req_o); // R11

endmodule

bind scan_sequencer scan_sequencer_chk #(.NSLOT(NSLOT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .stop_a_i      (stop_a_i),
    .conv_a_req_o  (conv_a_req_o),
    .conv_a_done_i (conv_a_done_i),
    .conv_b_req_o  (conv_b_req_o),
    .conv_b_done_i (conv_b_done_i),
    .ready_o       (ready_o),
    .ready_clr_i   (ready_clr_i),
    .eos_o         (eos_o)
);

// File: tb/tb_scan_sequencer.sv
`timescale 1ns/1ps
module tb_scan_sequencer;
    localparam int NSLOT = 16;
    localparam int CHW   = 4;
    localparam int RW    = 12;
    localparam int HALF  = NSLOT / 2;
    localparam int LAT   = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [1:0]           mode_i = '0;
    logic [1:0]           rpt_a_i = '0;
    logic [1:0]           rpt_b_i = '0;
    logic [NSLOT-1:0]     slot_en_i = '0;
    logic [NSLOT*CHW-1:0] slot_chan_i = '0;
    logic start_a_i = 0, stop_a_i = 0, sync_a_i = 0, sync_en_a_i = 0;
    logic start_b_i = 0, stop_b_i = 0, sync_b_i = 0, sync_en_b_i = 0;
    logic                 conv_a_req_o, conv_b_req_o;
    logic [CHW-1:0]       conv_a_chan_o, conv_b_chan_o;
    logic                 conv_a_done_i = 0, conv_b_done_i = 0;
    logic [RW-1:0]        conv_a_data_i = '0, conv_b_data_i = '0;
    logic [NSLOT-1:0]     ready_o;
    logic [NSLOT-1:0]     ready_clr_i = '0;
    logic [1:0]           eos_o;
    logic [1:0]           eos_clr_i = '0;
    logic [NSLOT*RW-1:0]  result_o;

    int nchk = 0, nerr = 0;
    int nreq_a = 0, nreq_b = 0, overlap = 0;
    int log_a [0:255];
    int log_b [0:255];
    int tag = 0;
    logic pend_a = 0, pend_b = 0;
    int cnt_a = 0, cnt_b = 0;
    logic [CHW-1:0] ch_a = '0, ch_b = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    scan_sequencer #(.NSLOT(NSLOT), .CHW(CHW), .RW(RW)) dut (.*);

    function automatic int chan_of(int s);
        return (s * 5 + 3) % 16;
    endfunction

    function automatic logic [RW-1:0] data_of(int conv, int ch);
        return RW'(conv * 2048 + ch * 8 + tag);
    endfunction

    // Fixed-latency converter models with request logs.
    always @(posedge clk) begin
        conv_a_done_i <= 1'b0;
        conv_b_done_i <= 1'b0;
        if (pend_a) begin
            if (cnt_a == 0) begin
                conv_a_done_i <= 1'b1;
                conv_a_data_i <= data_of(0, int'(ch_a));
                pend_a <= 1'b0;
            end else cnt_a <= cnt_a - 1;
        end
        if (pend_b) begin
            if (cnt_b == 0) begin
                conv_b_done_i <= 1'b1;
                conv_b_data_i <= data_of(1, int'(ch_b));
                pend_b <= 1'b0;
            end else cnt_b <= cnt_b - 1;
        end
        if (rst_n && conv_a_req_o) begin
            if (pend_a) overlap++;
            pend_a <= 1'b1; cnt_a <= LAT; ch_a <= conv_a_chan_o;
            if (nreq_a < 256) log_a[nreq_a] = int'(conv_a_chan_o);
            nreq_a++;
        end
        if (rst_n && conv_b_req_o) begin
            if (pend_b) overlap++;
            pend_b <= 1'b1; cnt_b <= LAT; ch_b <= conv_b_chan_o;
            if (nreq_b < 256) log_b[nreq_b] = int'(conv_b_chan_o);
            nreq_b++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string r, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic clear_all();
        ready_clr_i = '1; eos_clr_i = '1;
        tick(1);
        ready_clr_i = '0; eos_clr_i = '0;
        nreq_a = 0; nreq_b = 0;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: start_a_i = 1;
            1: start_b_i = 1;
            2: sync_a_i = 1;
            default: sync_b_i = 1;
        endcase
        tick(1);
        start_a_i = 0; start_b_i = 0; sync_a_i = 0; sync_b_i = 0;
    endtask

    task automatic check_scan(input string r, input int mask, input int ea,
                              input int eb, input int e0, input int e1);
        int bad = 0;
        int bad_ord = 0;
        chk(ready_o == NSLOT'(mask), r, "ready mask", ready_o, mask);
        chk(nreq_a == ea, r, "requests on A", nreq_a, ea);
        chk(nreq_b == eb, r, "requests on B", nreq_b, eb);
        chk(eos_o == 2'(e1 * 2 + e0), r, "eos flags", eos_o, e1 * 2 + e0);
        for (int s = 0; s < NSLOT; s++) begin
            if (mask[s] && result_o[s*RW +: RW] != data_of(s >= HALF, chan_of(s)))
                bad++;
        end
        chk(bad == 0, "R9", "result mismatches", bad, 0);
        for (int k = 0; k < ea && k < 256; k++)
            if (log_a[k] != chan_of(k)) bad_ord++;
        for (int k = 0; k < eb && k < 256; k++)
            if (log_b[k] != chan_of(HALF + k)) bad_ord++;
        chk(bad_ord == 0, "R13", "channel order mismatches", bad_ord, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int s = 0; s < NSLOT; s++) slot_chan_i[s*CHW +: CHW] = CHW'(chan_of(s));
        tick(4);
        rst_n = 1;
        tick(2);
        // R1 reset state
        chk(ready_o == '0, "R1", "ready after reset", ready_o, 0);
        chk(eos_o == '0, "R1", "eos after reset", eos_o, 0);
        chk(!conv_a_req_o && !conv_b_req_o && nreq_a == 0 && nreq_b == 0,
            "R1", "requests after reset", nreq_a + nreq_b, 0);

        // R2 / R3 / R10: sequential sweep over the first disabled slot
        mode_i = 2'd0; rpt_a_i = 2'd0;
        for (int n = 0; n <= NSLOT; n++) begin
            tag = n % 8;
            slot_en_i = (n < NSLOT) ? ~NSLOT'(1 << n) : '1;
            clear_all();
            pulse(0);
            tick(130);
            check_scan(n == 0 ? "R10" : (n == NSLOT ? "R3" : "R2"),
                       (1 << n) - 1, n < HALF ? n : HALF, n > HALF ? n - HALF : 0, 1, 0);
        end

        // R4: simultaneous sweep over both prefix lengths
        mode_i = 2'd1;
        for (int na = 0; na <= HALF; na++) begin
            for (int nb = 0; nb <= HALF; nb++) begin
                int m;
                m = na < nb ? na : nb;
                tag = (na + nb) % 8;
                slot_en_i = '1;
                if (na < HALF) slot_en_i[na] = 1'b0;
                if (nb < HALF) slot_en_i[HALF + nb] = 1'b0;
                clear_all();
                pulse(0);
                tick(70);
                check_scan("R4", ((1 << m) - 1) | (((1 << m) - 1) << HALF), m, m, 1, 0);
            end
        end
        // R4: B-side start has no effect in simultaneous mode
        slot_en_i = '1;
        clear_all();
        pulse(1);
        tick(40);
        chk(nreq_a == 0 && nreq_b == 0 && eos_o == 0, "R4", "B start ignored",
            nreq_a + nreq_b, 0);

        // R5: independent mode
        mode_i = 2'd2; rpt_b_i = 2'd0; tag = 1;
        slot_en_i = '1; slot_en_i[5] = 0; slot_en_i[HALF + 3] = 0;
        clear_all();
        pulse(0);
        tick(70);
        check_scan("R5", 32'h1f, 5, 0, 1, 0);
        clear_all();
        pulse(1);
        tick(70);
        check_scan("R5", 32'h7 << HALF, 0, 3, 0, 1);
        slot_en_i = '1; slot_en_i[HALF + 2] = 0; tag = 2;
        clear_all();
        start_a_i = 1; start_b_i = 1;
        tick(1);
        start_a_i = 0; start_b_i = 0;
        tick(70);
        check_scan("R5", 32'hff | (32'h3 << HALF), 8, 2, 1, 1);
        // R11 / R5: stop B mid-conversion while A runs on
        slot_en_i = '1; tag = 3;
        clear_all();
        start_a_i = 1; start_b_i = 1;
        tick(1);
        start_a_i = 0; start_b_i = 0;
        tick(1);
        stop_b_i = 1;
        tick(12);
        stop_b_i = 0;
        tick(60);
        check_scan("R11", 32'hff, 8, 1, 1, 0);

        // R6: sync ignored in once mode
        mode_i = 2'd0; rpt_a_i = 2'd0; sync_en_a_i = 1; slot_en_i = '1;
        clear_all();
        pulse(2);
        tick(20);
        chk(nreq_a == 0 && eos_o == 0, "R6", "sync in once mode", nreq_a, 0);

        // R8: triggered mode
        rpt_a_i = 2'd2; sync_en_a_i = 0; tag = 4;
        clear_all();
        pulse(2);
        tick(20);
        chk(nreq_a == 0 && eos_o == 0, "R8", "sync with enable low", nreq_a, 0);
        sync_en_a_i = 1;
        slot_en_i = '1; slot_en_i[4] = 0;
        clear_all();
        pulse(2);
        tick(10);
        pulse(2);
        tick(60);
        check_scan("R8", 32'hf, 4, 0, 1, 0);

        // R7: looping mode, restarts, ignored pulses, stop
        rpt_a_i = 2'd1; tag = 5;
        slot_en_i = '1; slot_en_i[3] = 0;
        clear_all();
        pulse(0);
        tick(40);
        pulse(0);
        tick(5);
        pulse(2);
        tick(60);
        begin
            int bad = 0;
            int n1;
            chk(nreq_a >= 6, "R7", "loop restarts", nreq_a, 6);
            for (int k = 0; k < nreq_a && k < 256; k++)
                if (log_a[k] != chan_of(k % 3)) bad++;
            chk(bad == 0, "R7", "loop slot order", bad, 0);
            chk(eos_o[0] == 1'b1, "R7", "loop eos", eos_o, 1);
            stop_a_i = 1;
            tick(20);
            n1 = nreq_a;
            tick(30);
            chk(nreq_a == n1, "R7", "requests after stop", nreq_a, n1);
            stop_a_i = 0;
            tick(30);
            chk(nreq_a == n1, "R7", "no restart after stop release", nreq_a, n1);
        end

        // R10: empty scan does not loop
        slot_en_i = '1; slot_en_i[0] = 0;
        clear_all();
        pulse(0);
        tick(20);
        chk(nreq_a == 0 && nreq_b == 0 && eos_o == 2'b01, "R10", "empty loop scan",
            eos_o, 1);

        // R11: stop during the third conversion in sequential once mode
        rpt_a_i = 2'd0; slot_en_i = '1; tag = 6;
        clear_all();
        pulse(0);
        for (int w = 0; w < 100 && nreq_a < 3; w++) tick(1);
        stop_a_i = 1;
        tick(15);
        stop_a_i = 0;
        tick(5);
        chk(ready_o == 16'h0003, "R11", "ready after stop", ready_o, 3);
        chk(eos_o == 0, "R11", "no eos on stop", eos_o, 0);
        chk(nreq_a == 3, "R11", "requests after stop", nreq_a, 3);

        // R9: write-one clear of selected flags
        tag = 7;
        clear_all();
        pulse(0);
        tick(130);
        chk(ready_o == '1, "R9", "ready before clear", ready_o, 16'hffff);
        ready_clr_i = 16'h00f0; eos_clr_i = 2'b01;
        tick(1);
        ready_clr_i = '0; eos_clr_i = '0;
        chk(ready_o == 16'hff0f, "R9", "ready after clear", ready_o, 16'hff0f);
        chk(eos_o == 0, "R9", "eos after clear", eos_o, 0);

        chk(overlap == 0, "R12", "overlapping requests", overlap, 0);
        summary();
    end

endmodule